// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns logical addresses into physical addresses for a small paged memory system. A request carries a logical address and a read/write flag. The upper bits of the address select a page, and the lower bits are an offset inside that page. The page number is searched in a small fully associative translation cache. On a hit, the frame number held in the cache is joined with the offset, and the result is returned on the following cycle.

On a miss, the block reads one page-table entry from memory. The entry's address is the table base input plus the page number, and the memory may answer after any number of cycles. A valid entry is written into the cache. Its slot is chosen round-robin among the slots that are not locked. The translation is then returned. Requests that hit an invalid page, or that write to a read-only page, come back with a trap flag and a cause code instead of an address.

A request may ask for its refill to be locked. A locked slot is never chosen as a victim and survives a flush. A flush input, raised by software whenever the table base changes, clears every unlocked slot in one cycle.

Top module: `paged_xlate`

## Requirements
- R1: The page number is `req_addr[VA_W-1:OFF_W]`, the offset is `req_addr[OFF_W-1:0]`, and a successful translation returns `{frame, offset}` (frame times page size plus offset). With 4-byte pages, page 2 in frame 1 maps address 10 to 6, and page 1 in frame 6 maps addresses 4 and 7 to 24 and 27.
- R2: A request whose page is cached is answered with `resp_valid` one cycle after acceptance, and no memory read is issued.
- R3: A request that misses issues one read at `ptb + page number` in the cycle after acceptance. `req_ready` stays low until the response is given. `resp_valid` rises in the cycle after `mem_rd_valid`, for any memory latency of one cycle or more.
- R4: A table entry is `{valid, writable, frame}`, with valid at bit FRAME_W+1, writable at bit FRAME_W and the frame below them. A valid entry fetched on a miss is cached, so the next access to that page hits. At most one slot ever matches a page.
- R5: An entry with valid = 0 gives `resp_trap` = 1, `resp_cause` = 1 and `resp_paddr` = 0. Such an entry is not cached.
- R6: A write to a page whose writable bit is 0 gives `resp_trap` = 1, `resp_cause` = 2 and `resp_paddr` = 0. A read of the same page translates normally. A response without a trap carries `resp_cause` = 0.
- R7: A refill goes into the first unlocked slot at or after a round-robin pointer, wrapping around. The pointer then moves to the slot after the one written. The pointer starts at slot 0 after reset.
- R8: A refill requested with `req_pin` = 1 becomes locked. A locked slot is never replaced and is kept by a flush.
- R9: When every slot is locked, a miss still completes, but the entry is not cached, so the next access to that page misses again.
- R10: `flush` = 1 for one cycle invalidates every unlocked slot, so the next access to those pages misses.
- R11: If `flush` is high in the same cycle that a refill completes, an unlocked refill is discarded, but a locked refill is installed.
- R12: `mem_rd_en` is high for exactly one cycle per table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptb | input | PTB_W | Base address of the page table in memory |
| flush | input | 1 | Invalidate all unlocked cache slots |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | VA_W | Logical address |
| req_write | input | 1 | Access is a write |
| req_pin | input | 1 | Lock the slot filled by this request's refill |
| resp_valid | output | 1 | Response present for one cycle |
| resp_paddr | output | FRAME_W+OFF_W | Physical address, zero on a trap |
| resp_trap | output | 1 | Access faulted |
| resp_cause | output | 2 | 0 none, 1 invalid page, 2 write to read-only page |
| mem_addr | output | PTB_W | Table entry address |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_data | input | FRAME_W+2 | Table entry returned |
| mem_rd_valid | input | 1 | `mem_rd_data` is valid |

## Verification
A flush can arrive in the very cycle that a refill finishes. The flush clears slots, and the refill writes one, so the two collide. The bench provokes this from its memory model by raising `flush` on the same clock edge as `mem_rd_valid`. It does this once for an unlocked refill and once for a locked refill. It then judges the outcome by whether the next access to that page causes a table read. The rest of the run compares every response against a cache model held in the bench. This covers all 64 addresses at varying memory latency, a reset with a new table base, and the case where every slot is locked.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_PROT    = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_ISSUE,
        WALK_WAIT
    } walk_e;

    // Decide the fault class of one access.
    function automatic cause_e classify(input logic present,
                                        input logic writable,
                                        input logic is_write);
        if (!present)
            return CAUSE_INVALID;
        if (is_write && !writable)
            return CAUSE_PROT;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 4,
    parameter int FRAME_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [ENTRIES-1:0] lk_hit_vec,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               lk_writable,
    input  logic               fill_en,
    input  logic               fill_pin,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_writable
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic               valid;
        logic               pinned;
        logic               writable;
        logic [VPN_W-1:0]   vpn;
        logic [FRAME_W-1:0] frame;
    } slot_t;

    slot_t            slots [ENTRIES];
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] victim;
    logic             victim_found;
    logic             fill_go;

    // Per-slot tag compare.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign lk_hit_vec[g] = slots[g].valid && (slots[g].vpn == lk_vpn);
    end

    assign lk_hit = |lk_hit_vec;

    always_comb begin
        lk_frame    = '0;
        lk_writable = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (lk_hit_vec[k]) begin
                lk_frame    = lk_frame | slots[k].frame;
                lk_writable = lk_writable | slots[k].writable;
            end
        end
    end

    // Round-robin victim: first unlocked slot at or after the pointer.
    always_comb begin
        victim_found = 1'b0;
        victim       = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            int unsigned cand;
            cand = (int'(rr_q) + k) % ENTRIES;
            if (!victim_found && !slots[cand].pinned) begin
                victim_found = 1'b1;
                victim       = IDX_W'(cand);
            end
        end
    end

    assign fill_go = fill_en && victim_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ENTRIES; k++)
                slots[k] <= '0;
            rr_q <= '0;
        end else begin
            for (int k = 0; k < ENTRIES; k++) begin
                if (fill_go && (victim == IDX_W'(k))) begin
                    slots[k].valid    <= 1'b1;
                    slots[k].pinned   <= fill_pin;
                    slots[k].writable <= fill_writable;
                    slots[k].vpn      <= fill_vpn;
                    slots[k].frame    <= fill_frame;
                end else if (flush && !slots[k].pinned) begin
                    slots[k].valid <= 1'b0;
                end
            end
            if (fill_go)
                rr_q <= (int'(victim) + 1 >= ENTRIES) ? '0 : victim + 1'b1;
        end
    end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import mmu_pkg::*;
#(
    parameter int VPN_W = 4,
    parameter int PTB_W = 8,
    parameter int PTE_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [PTB_W-1:0] ptb,
    output logic             idle,
    output logic             done,
    output logic [PTE_W-1:0] pte,
    output logic [PTB_W-1:0] mem_addr,
    output logic             mem_rd_en,
    input  logic [PTE_W-1:0] mem_rd_data,
    input  logic             mem_rd_valid
);
    walk_e            state_q;
    logic [PTB_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                WALK_IDLE: if (start) begin
                    addr_q  <= ptb + PTB_W'(start_vpn);
                    state_q <= WALK_ISSUE;
                end
                WALK_ISSUE: state_q <= WALK_WAIT;
                WALK_WAIT:  if (mem_rd_valid) state_q <= WALK_IDLE;
                default:    state_q <= WALK_IDLE;
            endcase
        end
    end

    assign idle      = (state_q == WALK_IDLE);
    assign mem_rd_en = (state_q == WALK_ISSUE);
    assign mem_addr  = addr_q;
    assign done      = (state_q == WALK_WAIT) && mem_rd_valid;
    assign pte       = mem_rd_data;

endmodule

// File: rtl/xlate_resp.sv
module xlate_resp
    import mmu_pkg::*;
#(
    parameter int FRAME_W = 4,
    parameter int OFF_W   = 2
) (
    input  logic                     present,
    input  logic                     writable,
    input  logic                     is_write,
    input  logic [FRAME_W-1:0]       frame,
    input  logic [OFF_W-1:0]         offset,
    output logic [FRAME_W+OFF_W-1:0] paddr,
    output logic                     trap,
    output logic [1:0]               cause
);
    cause_e c;

    always_comb begin
        c     = classify(present, writable, is_write);
        cause = c;
        trap  = (c != CAUSE_NONE);
        paddr = trap ? '0 : {frame, offset};
    end

endmodule

// File: rtl/paged_xlate.sv
module paged_xlate
    import mmu_pkg::*;
#(
    parameter int VA_W    = 6,
    parameter int OFF_W   = 2,
    parameter int FRAME_W = 4,
    parameter int ENTRIES = 4,
    parameter int PTB_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PTB_W-1:0]         ptb,
    input  logic                     flush,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VA_W-1:0]          req_addr,
    input  logic                     req_write,
    input  logic                     req_pin,
    output logic                     resp_valid,
    output logic [FRAME_W+OFF_W-1:0] resp_paddr,
    output logic                     resp_trap,
    output logic [1:0]               resp_cause,
    output logic [PTB_W-1:0]         mem_addr,
    output logic                     mem_rd_en,
    input  logic [FRAME_W+1:0]       mem_rd_data,
    input  logic                     mem_rd_valid
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = FRAME_W + OFF_W;
    localparam int PTE_W = FRAME_W + 2;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
        logic             write;
        logic             pin;
    } pend_t;

    pend_t              pend_q;
    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic               accept, hit_go, walk_start;
    logic               walk_idle, walk_done;
    logic [PTE_W-1:0]   pte;
    logic               lk_hit, lk_writable;
    logic [ENTRIES-1:0] hit_vec;
    logic [FRAME_W-1:0] lk_frame;
    logic               fill_en;

    logic               sel_present, sel_writable, sel_write;
    logic [FRAME_W-1:0] sel_frame;
    logic [OFF_W-1:0]   sel_off;
    logic [PA_W-1:0]    nxt_paddr;
    logic               nxt_trap;
    logic [1:0]         nxt_cause;

    assign req_vpn    = req_addr[VA_W-1:OFF_W];
    assign req_off    = req_addr[OFF_W-1:0];
    assign req_ready  = walk_idle;
    assign accept     = req_valid && req_ready;
    assign hit_go     = accept && lk_hit;
    assign walk_start = accept && !lk_hit;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= '0;
        else if (accept)
            pend_q <= '{vpn: req_vpn, off: req_off, write: req_write, pin: req_pin};
    end

    xlate_tlb #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .FRAME_W(FRAME_W)
    ) tlb_i (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .lk_vpn       (req_vpn),
        .lk_hit       (lk_hit),
        .lk_hit_vec   (hit_vec),
        .lk_frame     (lk_frame),
        .lk_writable  (lk_writable),
        .fill_en      (fill_en),
        .fill_pin     (pend_q.pin),
        .fill_vpn     (pend_q.vpn),
        .fill_frame   (pte[FRAME_W-1:0]),
        .fill_writable(pte[FRAME_W])
    );

    xlate_walker #(
        .VPN_W(VPN_W),
        .PTB_W(PTB_W),
        .PTE_W(PTE_W)
    ) walk_i (
        .clk         (clk),
        .rst         (rst),
        .start       (walk_start),
        .start_vpn   (req_vpn),
        .ptb         (ptb),
        .idle        (walk_idle),
        .done        (walk_done),
        .pte         (pte),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_data (mem_rd_data),
        .mem_rd_valid(mem_rd_valid)
    );

    // Valid refill is cached unless a flush in the same cycle discards it.
    assign fill_en = walk_done && pte[PTE_W-1] && !(flush && !pend_q.pin);

    // Response source: fetched entry on walk completion, cache otherwise.
    always_comb begin
        if (walk_done) begin
            sel_present  = pte[PTE_W-1];
            sel_writable = pte[FRAME_W];
            sel_frame    = pte[FRAME_W-1:0];
            sel_off      = pend_q.off;
            sel_write    = pend_q.write;
        end else begin
            sel_present  = 1'b1;
            sel_writable = lk_writable;
            sel_frame    = lk_frame;
            sel_off      = req_off;
            sel_write    = req_write;
        end
    end

    xlate_resp #(
        .FRAME_W(FRAME_W),
        .OFF_W  (OFF_W)
    ) resp_i (
        .present (sel_present),
        .writable(sel_writable),
        .is_write(sel_write),
        .frame   (sel_frame),
        .offset  (sel_off),
        .paddr   (nxt_paddr),
        .trap    (nxt_trap),
        .cause   (nxt_cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_trap  <= 1'b0;
            resp_cause <= 2'd0;
        end else begin
            resp_valid <= hit_go || walk_done;
            if (hit_go || walk_done) begin
                resp_paddr <= nxt_paddr;
                resp_trap  <= nxt_trap;
                resp_cause <= nxt_cause;
            end
        end
    end

endmodule

// File: rtl/paged_xlate_chk.sv
module paged_xlate_chk #(
    parameter int PA_W    = 6,
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               lk_hit,
    input logic [ENTRIES-1:0] hit_vec,
    input logic               mem_rd_en,
    input logic               resp_valid,
    input logic               resp_trap,
    input logic [1:0]         resp_cause,
    input logic [PA_W-1:0]    resp_paddr
);
    assert_hit_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lk_hit) |=> (resp_valid && !mem_rd_en));

    assert_miss_reads_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !lk_hit) |=> (mem_rd_en && !req_ready && !resp_valid));

    assert_single_match_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_trap_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_trap) |-> (resp_paddr == '0 && resp_cause != 2'd0));

    assert_clean_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_trap) |-> (resp_cause == 2'd0));

    assert_read_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

endmodule

bind paged_xlate paged_xlate_chk #(
    .PA_W   (PA_W),
    .ENTRIES(ENTRIES)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lk_hit    (lk_hit),
    .hit_vec   (hit_vec),
    .mem_rd_en (mem_rd_en),
    .resp_valid(resp_valid),
    .resp_trap (resp_trap),
    .resp_cause(resp_cause),
    .resp_paddr(resp_paddr)
);

// File: tb/paged_xlate_tb_top.sv
module paged_xlate_tb_top;
    localparam int VA_W    = 6;
    localparam int OFF_W   = 2;
    localparam int FRAME_W = 4;
    localparam int ENTRIES = 4;
    localparam int PTB_W   = 8;
    localparam int PA_W    = FRAME_W + OFF_W;
    localparam int PTE_W   = FRAME_W + 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [PTB_W-1:0]   ptb = '0;
    logic               flush = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [VA_W-1:0]    req_addr = '0;
    logic               req_write = 1'b0;
    logic               req_pin = 1'b0;
    logic               resp_valid;
    logic [PA_W-1:0]    resp_paddr;
    logic               resp_trap;
    logic [1:0]         resp_cause;
    logic [PTB_W-1:0]   mem_addr;
    logic               mem_rd_en;
    logic [PTE_W-1:0]   mem_rd_data = '0;
    logic               mem_rd_valid = 1'b0;

    always #10 clk = ~clk;

    paged_xlate #(
        .VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
        .ENTRIES(ENTRIES), .PTB_W(PTB_W)
    ) dut_i (
        .clk(clk), .rst(rst), .ptb(ptb), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_pin(req_pin),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_trap(resp_trap), .resp_cause(resp_cause),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid)
    );

    int checks = 0;
    int errors = 0;

    logic [PTE_W-1:0] ptmem [256];
    int               lat_cfg = 1;
    bit               flush_with_data = 1'b0;
    int               rd_cnt = 0;
    logic [PTB_W-1:0] rd_addr_seen = '0;

    // Bench model of the translation cache.
    logic [3:0]         m_vpn  [ENTRIES];
    logic [FRAME_W-1:0] m_frame[ENTRIES];
    bit                 m_wr   [ENTRIES];
    bit                 m_val  [ENTRIES];
    bit                 m_pin  [ENTRIES];
    int                 m_rr;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Page-table memory with configurable latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_en) begin
                rd_addr_seen = mem_addr;
                @(negedge clk);
                for (int w = 1; w < lat_cfg; w++) @(negedge clk);
                mem_rd_valid = 1'b1;
                mem_rd_data  = ptmem[rd_addr_seen];
                if (flush_with_data) flush = 1'b1;
                @(negedge clk);
                mem_rd_valid = 1'b0;
                flush        = 1'b0;
            end
        end
    end

    always @(negedge clk) if (mem_rd_en) rd_cnt++;

    function automatic int find(input logic [3:0] v);
        for (int k = 0; k < ENTRIES; k++)
            if (m_val[k] && m_vpn[k] == v) return k;
        return -1;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < ENTRIES; k++) begin
            m_val[k] = 0; m_pin[k] = 0; m_vpn[k] = '0; m_frame[k] = '0; m_wr[k] = 0;
        end
        m_rr = 0;
    endtask

    task automatic model_flush();
        for (int k = 0; k < ENTRIES; k++) if (!m_pin[k]) m_val[k] = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_flush();
    endtask

    task automatic fill_table(input logic [PTB_W-1:0] base, input int variant);
        for (int v = 0; v < 16; v++) begin
            bit vl, wl;
            logic [3:0] fr;
            if (variant == 0) begin
                vl = (v < 14);
                wl = (v % 2 == 0);
                fr = 4'((v * 5 + 9) % 16);
                if (v == 1) fr = 4'd6;
                if (v == 2) fr = 4'd1;
            end else begin
                vl = (v != 3);
                wl = (v < 8);
                fr = 4'(15 - v);
            end
            ptmem[8'(base + 8'(v))] = {vl, wl, fr};
        end
    endtask

    task automatic do_req(input logic [VA_W-1:0] a, input bit wr, input bit pin,
                          input int lat, input bit fl, input string tag);
        logic [3:0]         vpn;
        int                 idx, n, start_cnt, exp_cause;
        bit                 present, writ, exp_hit;
        logic [FRAME_W-1:0] fr;
        logic [PTE_W-1:0]   pe;
        logic [PTB_W-1:0]   exp_addr;
        int                 exp_paddr;
        vpn      = a[5:2];
        idx      = find(vpn);
        exp_hit  = (idx >= 0);
        exp_addr = ptb + 8'(vpn);
        pe       = ptmem[exp_addr];
        if (exp_hit) begin
            present = 1; writ = m_wr[idx]; fr = m_frame[idx];
        end else begin
            present = pe[PTE_W-1]; writ = pe[FRAME_W]; fr = pe[FRAME_W-1:0];
        end
        exp_cause = !present ? 1 : (wr && !writ) ? 2 : 0;
        exp_paddr = (exp_cause != 0) ? 0 : int'({fr, a[1:0]});

        lat_cfg = lat;
        flush_with_data = fl;
        @(negedge clk);
        chk(req_ready == 1'b1, "R3", "req_ready before request", int'(req_ready), 1);
        start_cnt = rd_cnt;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_pin = pin;
        @(negedge clk);
        req_valid = 1'b0; req_pin = 1'b0; req_write = 1'b0;
        n = 1;
        if (!exp_hit)
            chk(req_ready == 1'b0, "R3", "req_ready low during walk", int'(req_ready), 0);
        while (!resp_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (exp_hit) begin
            chk(n == 1, "R2", {tag, " hit latency"}, n, 1);
            chk(rd_cnt == start_cnt, "R2", {tag, " no table read on hit"}, rd_cnt - start_cnt, 0);
        end else begin
            chk(n == 2 + lat, "R3", {tag, " miss latency"}, n, 2 + lat);
            chk(rd_cnt - start_cnt == 1, "R12", {tag, " one read strobe"}, rd_cnt - start_cnt, 1);
            chk(rd_addr_seen == exp_addr, "R3", {tag, " entry address"},
                int'(rd_addr_seen), int'(exp_addr));
        end
        chk(int'(resp_cause) == exp_cause, exp_cause == 1 ? "R5" : exp_cause == 2 ? "R6" : "R1",
            {tag, " cause"}, int'(resp_cause), exp_cause);
        chk(resp_trap == (exp_cause != 0), "R6", {tag, " trap flag"}, int'(resp_trap),
            int'(exp_cause != 0));
        chk(int'(resp_paddr) == exp_paddr, "R1", {tag, " physical address"},
            int'(resp_paddr), exp_paddr);

        // Model update for a miss.
        if (!exp_hit && present && !(fl && !pin)) begin
            int victim = -1;
            for (int k = 0; k < ENTRIES; k++) begin
                int c = (m_rr + k) % ENTRIES;
                if (victim < 0 && !m_pin[c]) victim = c;
            end
            if (victim >= 0) begin
                m_val[victim] = 1; m_pin[victim] = pin; m_vpn[victim] = vpn;
                m_frame[victim] = fr; m_wr[victim] = writ;
                m_rr = (victim + 1) % ENTRIES;
            end
        end
        if (!exp_hit && fl) model_flush();
        flush_with_data = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ptmem[i] = '0;
        model_reset();
        ptb = 8'h20;
        fill_table(8'h20, 0);
        do_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R3", "reset req_ready", int'(req_ready), 1);
        chk(resp_valid == 1'b0, "R2", "reset resp_valid", int'(resp_valid), 0);
        chk(mem_rd_en == 1'b0, "R12", "reset mem_rd_en", int'(mem_rd_en), 0);

        // Worked examples with 4-byte pages.
        do_req(6'd10, 0, 0, 1, 0, "R1 addr10");
        do_req(6'd4,  0, 0, 2, 0, "R1 addr4");
        do_req(6'd7,  0, 0, 1, 0, "R1 addr7 R4 refill hit");
        chk(resp_paddr == 6'd27, "R1", "addr7 to 27", int'(resp_paddr), 27);

        // Sweeps over every address, reads and writes, varying latency.
        for (int pass = 0; pass < 2; pass++)
            for (int a = 0; a < 64; a++)
                do_req(6'(a), bit'((a + pass) % 2), 0, 1 + (a % 3), 0, "sweep R4 R5 R6");

        // Invalid entries are never cached.
        do_req({4'd14, 2'd1}, 0, 0, 1, 0, "R5 invalid first");
        do_req({4'd14, 2'd1}, 0, 0, 1, 0, "R5 invalid again");
        chk(resp_cause == 2'd1, "R5", "invalid cause", int'(resp_cause), 1);

        // Protection: write then read of a read-only page.
        do_req({4'd3, 2'd2}, 1, 0, 1, 0, "R6 write ro");
        do_req({4'd3, 2'd2}, 0, 0, 1, 0, "R6 read ro");

        // Round-robin order.
        do_flush();
        for (int v = 4; v < 9; v++) do_req({4'(v), 2'd0}, 0, 0, 1, 0, "R7 fill");
        do_req({4'd4, 2'd0}, 0, 0, 1, 0, "R7 victim check");
        do_req({4'd6, 2'd0}, 0, 0, 1, 0, "R7 survivor check");

        // Locked slots survive replacement and flush.
        do_flush();
        do_req({4'd9, 2'd1}, 0, 1, 2, 0, "R8 lock a");
        do_req({4'd10, 2'd1}, 0, 1, 1, 0, "R8 lock b");
        for (int v = 0; v < 6; v++) do_req({4'(v), 2'd0}, 0, 0, 1, 0, "R8 thrash");
        do_req({4'd9, 2'd1}, 0, 0, 1, 0, "R8 locked hit");
        do_flush();
        do_req({4'd10, 2'd2}, 0, 0, 1, 0, "R8 locked after flush");
        do_req({4'd0, 2'd0}, 0, 0, 1, 0, "R10 flushed page misses");

        // Flush in the same cycle as a refill.
        do_req({4'd5, 2'd0}, 0, 0, 2, 1, "R11 unlocked refill with flush");
        do_req({4'd5, 2'd0}, 0, 0, 1, 0, "R11 unlocked refill discarded");
        do_req({4'd6, 2'd0}, 0, 1, 1, 1, "R11 locked refill with flush");
        do_req({4'd6, 2'd0}, 0, 0, 1, 0, "R11 locked refill kept");

        // All slots locked.
        do_req({4'd7, 2'd0}, 0, 1, 1, 0, "R9 lock last");
        do_req({4'd8, 2'd3}, 0, 0, 1, 0, "R9 uncached first");
        do_req({4'd8, 2'd3}, 0, 0, 3, 0, "R9 uncached again");

        // New table base after reset.
        ptb = 8'h40;
        fill_table(8'h40, 1);
        do_reset();
        for (int a = 0; a < 64; a += 3)
            do_req(6'(a), bit'(a % 2), 0, 1 + (a % 2), 0, "R3 new base");

        summary();
        $finish;
    end

endmodule